// File: doc/BRIEF.md
# 16-to-32-bit Bus Master Bridge

This block lets a processor with a 16-bit register port run single 32-bit transfers as a Wishbone classic master. The processor cannot present a 32-bit address or data word in one access, so it builds the transfer from 16-bit register writes:

1. It writes the byte-lane enables into the control register.
2. It fills the two halves of the 32-bit data word.
3. It writes the lower half of the target address.
4. It writes the upper half of the address. This last write launches the bus cycle.

There are two address register pairs, one for reads and one for writes. The pair whose upper half is written decides whether the cycle reads or writes.

While the cycle is open, the control register reports a pending flag. When the slave acknowledges a read, the returned 32-bit word is stored in the two data registers in the same clock. Software then reads it back 16 bits at a time. A trigger that arrives while a cycle is still open is dropped. Address, direction and byte enables are frozen at launch.

Top module: `wb16_bridge`

## Requirements
- R1: After reset the bus cycle is idle (`wb_cyc_o` and `wb_stb_o` low). The control register reads 0x0000, and both data registers read 0x0000.
- R2: Writing the upper read-address half (byte offset 4) while idle opens a read cycle from the next clock. `wb_cyc_o` and `wb_stb_o` go high, `wb_we_o` stays low, and `wb_adr_o` equals {value written at offset 4, value last written at offset 2}.
- R3: Writing the upper write-address half (byte offset 8) while idle opens a write cycle from the next clock. `wb_we_o` goes high, `wb_adr_o` equals {value written at offset 8, value last written at offset 6}, and `wb_dat_o` equals {data at offset 12, data at offset 10}.
- R4: Bits 3:0 of the last write to the control register (offset 0) appear on `wb_sel_o` for the whole of the cycle that follows.
- R5: Reading offset 0 returns bit 15 set while a cycle is open and 0 otherwise. All other bits read 0.
- R6: `wb_cyc_o` and `wb_stb_o` stay high until a clock edge that sees `wb_ack_i` high. They are low from the clock after that edge.
- R7: At the acknowledging edge of a read, `wb_dat_i[15:0]` is stored into the data register at offset 10 and `wb_dat_i[31:16]` into the one at offset 12. A write cycle leaves both data registers unchanged.
- R8: A trigger write (offset 4 or 8) during an open cycle is ignored. `wb_adr_o`, `wb_we_o` and `wb_sel_o` keep their values until the cycle ends.
- R9: Reads of offsets 2, 4, 6, 8 and 14 return 0x0000.
- R10: The data registers at offsets 10 and 12 read back the last 16-bit value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_ofs | input | 4 | Register byte offset (bit 0 ignored) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_ofs` (combinational) |
| wb_adr_o | output | 32 | Bus address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_sel_o | output | 4 | Byte-lane enables |
| wb_we_o | output | 1 | Write enable |
| wb_cyc_o | output | 1 | Cycle valid |
| wb_stb_o | output | 1 | Strobe |
| wb_ack_i | input | 1 | Slave acknowledge |

## Verification
The main function is tried with reads and writes in random mix, random 32-bit addresses, data and byte enables, and slave latencies from zero to five waiting cycles. Random latency separates a cycle that closes on the acknowledge from one that closes early or hangs. Mixing directions shows whether the correct address pair and write-enable follow the trigger offset, and whether captured read data is kept apart from write data that must survive.

Some transactions inject an opposite-direction trigger mid-cycle, to prove it leaves the open cycle untouched. Directed cases cover the reset state, zero-reading offsets after the address registers hold nonzero values, and data register readback.

// File: rtl/wb16_bridge_pkg.sv
package wb16_bridge_pkg;

    localparam int REG_W   = 16;
    localparam int DATA_W  = 2 * REG_W;
    localparam int SEL_W   = DATA_W / 8;
    localparam int OFS_W   = 4;
    localparam int BUSY_BIT = REG_W - 1;

    typedef enum logic [2:0] {
        SLOT_CTRL    = 3'd0,
        SLOT_RADR_LO = 3'd1,
        SLOT_RADR_HI = 3'd2,
        SLOT_WADR_LO = 3'd3,
        SLOT_WADR_HI = 3'd4,
        SLOT_DAT_LO  = 3'd5,
        SLOT_DAT_HI  = 3'd6,
        SLOT_RSVD    = 3'd7
    } slot_e;

    typedef struct packed {
        logic              go;
        logic              we;
        logic [DATA_W-1:0] adr;
        logic [SEL_W-1:0]  sel;
    } launch_t;

    function automatic slot_e slot_of(input logic [OFS_W-1:0] ofs);
        return slot_e'(ofs[OFS_W-1:1]);
    endfunction

    function automatic logic is_trigger(input slot_e s);
        return (s == SLOT_RADR_HI) || (s == SLOT_WADR_HI);
    endfunction

endpackage

// File: rtl/wb16_bridge_regs.sv
module wb16_bridge_regs
    import wb16_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              busy,
    input  logic              capture,
    input  logic [DATA_W-1:0] cap_data,
    output launch_t           launch,
    output logic [DATA_W-1:0] data_word
);

    localparam int HALVES = DATA_W / REG_W;

    slot_e             slot;
    logic [SEL_W-1:0]  sel_q;
    logic [REG_W-1:0]  rd_lo_q;
    logic [REG_W-1:0]  wr_lo_q;

    assign slot = slot_of(ofs);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            rd_lo_q <= '0;
            wr_lo_q <= '0;
        end else if (wr) begin
            case (slot)
                SLOT_CTRL:    sel_q   <= wdata[SEL_W-1:0];
                SLOT_RADR_LO: rd_lo_q <= wdata;
                SLOT_WADR_LO: wr_lo_q <= wdata;
                default: ;
            endcase
        end
    end

    // One register per 16-bit half of the data word; bus capture wins over software.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [REG_W-1:0] half_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                half_q <= '0;
            end else if (capture) begin
                half_q <= cap_data[h*REG_W +: REG_W];
            end else if (wr && (slot == slot_e'(SLOT_DAT_LO + h))) begin
                half_q <= wdata;
            end
        end
        assign data_word[h*REG_W +: REG_W] = half_q;
    end

    always_comb begin
        launch.go  = wr && !busy && is_trigger(slot);
        launch.we  = (slot == SLOT_WADR_HI);
        launch.adr = {wdata, launch.we ? wr_lo_q : rd_lo_q};
        launch.sel = sel_q;
    end

    always_comb begin
        case (slot)
            SLOT_CTRL:   rdata = {busy, {(REG_W-1){1'b0}}};
            SLOT_DAT_LO: rdata = data_word[REG_W-1:0];
            SLOT_DAT_HI: rdata = data_word[DATA_W-1:REG_W];
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/wb16_bridge_master.sv
module wb16_bridge_master
    import wb16_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  launch_t           launch,
    input  logic              ack,
    output logic              cyc,
    output logic              we,
    output logic [DATA_W-1:0] adr,
    output logic [SEL_W-1:0]  sel,
    output logic              capture
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= 1'b0;
            we  <= 1'b0;
            adr <= '0;
            sel <= '0;
        end else if (cyc) begin
            if (ack) cyc <= 1'b0;
        end else if (launch.go) begin
            cyc <= 1'b1;
            we  <= launch.we;
            adr <= launch.adr;
            sel <= launch.sel;
        end
    end

    assign capture = cyc && ack && !we;

endmodule

// File: rtl/wb16_bridge.sv
module wb16_bridge
    import wb16_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [DATA_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic [SEL_W-1:0]  wb_sel_o,
    output logic              wb_we_o,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    input  logic              wb_ack_i
);

    launch_t launch;
    logic    cyc;
    logic    capture;

    wb16_bridge_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .ofs       (bus_ofs),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .busy      (cyc),
        .capture   (capture),
        .cap_data  (wb_dat_i),
        .launch    (launch),
        .data_word (wb_dat_o)
    );

    wb16_bridge_master u_mst (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .ack     (wb_ack_i),
        .cyc     (cyc),
        .we      (wb_we_o),
        .adr     (wb_adr_o),
        .sel     (wb_sel_o),
        .capture (capture)
    );

    assign wb_cyc_o = cyc;
    assign wb_stb_o = cyc;

endmodule

// File: rtl/wb16_bridge_chk.sv
module wb16_bridge_chk
    import wb16_bridge_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [OFS_W-1:0]  bus_ofs,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [DATA_W-1:0] wb_adr_o,
    input logic [SEL_W-1:0]  wb_sel_o,
    input logic              wb_we_o,
    input logic              wb_cyc_o,
    input logic              wb_stb_o,
    input logic              wb_ack_i
);

    logic idle_read_trig;
    logic idle_write_trig;
    logic zero_slot;

    assign idle_read_trig  = !wb_cyc_o && bus_wr && (bus_ofs[3:1] == 3'd2);
    assign idle_write_trig = !wb_cyc_o && bus_wr && (bus_ofs[3:1] == 3'd4);
    assign zero_slot       = (bus_ofs[3:1] inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd7});

    a_r2_read_launch: assert property (@(posedge clk) disable iff (rst)
        idle_read_trig |=> (wb_cyc_o && wb_stb_o && !wb_we_o));

    a_r3_write_launch: assert property (@(posedge clk) disable iff (rst)
        idle_write_trig |=> (wb_cyc_o && wb_stb_o && wb_we_o));

    a_r5_busy_flag: assert property (@(posedge clk) disable iff (rst)
        (bus_ofs[3:1] == 3'd0) |-> (bus_rdata == {wb_cyc_o, {(REG_W-1){1'b0}}}));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && wb_stb_o));

    a_r6_close: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o);

    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && !wb_ack_i) |=> ($stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_sel_o)));

    a_r9_zero_read: assert property (@(posedge clk) disable iff (rst)
        zero_slot |-> (bus_rdata == '0));

endmodule

bind wb16_bridge wb16_bridge_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_ofs   (bus_ofs),
    .bus_rdata (bus_rdata),
    .wb_adr_o  (wb_adr_o),
    .wb_sel_o  (wb_sel_o),
    .wb_we_o   (wb_we_o),
    .wb_cyc_o  (wb_cyc_o),
    .wb_stb_o  (wb_stb_o),
    .wb_ack_i  (wb_ack_i)
);

// File: tb/sim_wb16_bridge.sv
`timescale 1ns/1ps
module sim_wb16_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [3:0]  bus_ofs;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [31:0] wb_adr_o, wb_dat_o, wb_dat_i;
    logic [3:0]  wb_sel_o;
    logic        wb_we_o, wb_cyc_o, wb_stb_o, wb_ack_i;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wb16_bridge u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_ofs(bus_ofs),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
        .wb_sel_o(wb_sel_o), .wb_we_o(wb_we_o), .wb_cyc_o(wb_cyc_o),
        .wb_stb_o(wb_stb_o), .wb_ack_i(wb_ack_i)
    );

    function automatic logic [31:0] join16(input logic [15:0] hi, input logic [15:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic [15:0] status_word(input logic open);
        return open ? 16'h8000 : 16'h0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] ofs, input logic [15:0] val);
        @(negedge clk);
        bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = val;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] ofs, output logic [15:0] val);
        bus_ofs = ofs;
        #1 val = bus_rdata;
    endtask

    logic [31:0] exp_dat;

    task automatic transfer(input bit is_wr, input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] s, input int lat, input logic [31:0] rd,
                            input bit inject);
        logic [15:0] v;
        reg_write(4'd0, {12'h0, s});
        reg_write(4'd10, d[15:0]);
        reg_write(4'd12, d[31:16]);
        exp_dat = d;
        reg_write(is_wr ? 4'd6 : 4'd2, a[15:0]);
        reg_write(is_wr ? 4'd8 : 4'd4, a[31:16]);
        check(is_wr ? "R3 cyc" : "R2 cyc", {30'b0, wb_cyc_o, wb_stb_o}, 32'h3);
        check(is_wr ? "R3 we" : "R2 we", {31'b0, wb_we_o}, {31'b0, is_wr});
        check(is_wr ? "R3 adr" : "R2 adr", wb_adr_o, a);
        check("R4 sel", {28'b0, wb_sel_o}, {28'b0, s});
        if (is_wr) check("R3 dat_o", wb_dat_o, d);
        reg_read(4'd0, v);
        check("R5 busy", {16'b0, v}, {16'b0, status_word(1'b1)});
        if (inject) begin
            reg_write(is_wr ? 4'd4 : 4'd8, ~a[31:16]);
            check("R8 adr kept", wb_adr_o, a);
            check("R8 we kept", {31'b0, wb_we_o}, {31'b0, is_wr});
            check("R8 sel kept", {28'b0, wb_sel_o}, {28'b0, s});
        end
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check("R6 held", {31'b0, wb_cyc_o}, 32'h1);
        end
        @(negedge clk);
        wb_ack_i = 1'b1; wb_dat_i = rd;
        @(negedge clk);
        wb_ack_i = 1'b0; wb_dat_i = ~rd;
        check("R6 closed", {30'b0, wb_cyc_o, wb_stb_o}, 32'h0);
        reg_read(4'd0, v);
        check("R5 idle", {16'b0, v}, {16'b0, status_word(1'b0)});
        if (!is_wr) exp_dat = rd;
        reg_read(4'd10, v);
        check("R7 data lo", {16'b0, v}, {16'b0, exp_dat[15:0]});
        reg_read(4'd12, v);
        check("R7 data hi", {16'b0, v}, {16'b0, exp_dat[31:16]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_wr = 1'b0; bus_ofs = 4'd0; bus_wdata = '0;
        wb_ack_i = 1'b0; wb_dat_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cyc/stb", {30'b0, wb_cyc_o, wb_stb_o}, 32'h0);
        reg_read(4'd0, v);  check("R1 ctrl", {16'b0, v}, 32'h0);
        reg_read(4'd10, v); check("R1 data lo", {16'b0, v}, 32'h0);
        reg_read(4'd12, v); check("R1 data hi", {16'b0, v}, 32'h0);
        // R10 data readback
        reg_write(4'd10, 16'hA5C3);
        reg_write(4'd12, 16'h1E7F);
        reg_read(4'd10, v); check("R10 lo", {16'b0, v}, 32'hA5C3);
        reg_read(4'd12, v); check("R10 hi", {16'b0, v}, 32'h1E7F);
        // R9 zero reads with nonzero contents behind them
        reg_write(4'd2, 16'hFFFF);
        reg_write(4'd6, 16'hFFFF);
        reg_write(4'd0, 16'hFFFF);
        reg_read(4'd0, v);  check("R9 ctrl sel write-only", {16'b0, v}, 32'h0);
        reg_read(4'd2, v);  check("R9 ofs2", {16'b0, v}, 32'h0);
        reg_read(4'd4, v);  check("R9 ofs4", {16'b0, v}, 32'h0);
        reg_read(4'd6, v);  check("R9 ofs6", {16'b0, v}, 32'h0);
        reg_read(4'd8, v);  check("R9 ofs8", {16'b0, v}, 32'h0);
        reg_read(4'd14, v); check("R9 ofs14", {16'b0, v}, 32'h0);
        // directed corners: zero latency, extreme values, injected triggers
        transfer(1'b0, 32'hFFFF_FFFF, 32'h0, 4'hF, 0, 32'hDEAD_BEEF, 1'b1);
        transfer(1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 4'h0, 0, 32'h1234_5678, 1'b1);
        transfer(1'b1, 32'h8000_0001, 32'h0F0F_F0F0, 4'h5, 3, 32'h0, 1'b0);
        // randomized mix
        for (int k = 0; k < 40; k++) begin
            transfer(1'($urandom), $urandom, $urandom, 4'($urandom),
                     int'($urandom_range(0, 5)), $urandom, 1'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule